// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a processor whose PC is 32 bits wide and whose instruction words are 16 bits wide. On every clock edge it picks the next PC from a small set of candidates. The candidates are the incremented PC, a jump target taken from a register, a return address popped from the stack, and handler or boot addresses built from pairs of 16-bit words at the bottom of instruction memory. The choice follows the decoded control class of the current instruction, the condition flags, and any pending exception.

Alongside the PC it offers two combinational outputs. One is the return value that a call or software interrupt pushes onto the stack, which is PC+1. The other is a per-flag clear request, raised when a conditional jump is taken, so that the jump consumes the flag it tested. The fetch path, the stack memory and hazard handling sit outside this block. Those parts supply the words, the targets and the popped values.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with {word 0, word 1} of `vec_words` and the halted state is cleared. Word k occupies bits [16k+15:16k], and in every word pair the lower-numbered word forms the upper half of the address.
- R2: Code 0 (sequential), and any code from 10 to 15, advances the PC by one at the next edge, wrapping modulo 2^32, when the block is not halted and no exception is pending.
- R3: Code 1 (halt) holds the PC and sets a sticky halted state. While halted, the PC stays fixed unless an exception or a control transfer arrives, and only reset clears the halted state.
- R4: Code 2 (jump) loads the PC from `jmp_target` at the next edge.
- R5: Codes 3, 4 and 5 test the zero, negative and carry flags, which are `flags` bits 0, 1 and 2. When the tested flag is 1, the PC loads `jmp_target`. Otherwise the instruction behaves as sequential.
- R6: In the same cycle that a conditional jump is taken, with no reset and no exception, `flag_clr` has exactly the tested flag's bit set. In all other cycles `flag_clr` is zero.
- R7: `push_val` always equals PC+1 in the same cycle. This is the value that code 6 (call) and code 8 (interrupt) push.
- R8: Code 6 (call) loads the PC from `jmp_target`.
- R9: Code 8 (interrupt) loads {word 8, word 9} when `int_idx` is 2. Otherwise it loads {word 6, word 7`}, so indices 1 and 3 act as index 0.
- R10: Codes 7 (return) and 9 (return from interrupt) load the PC from `pop_addr`.
- R11: With `exc_valid` high, the PC loads {word 2, word 3} when `exc_kind` is 0 (empty stack) and {word 4, word 5} when `exc_kind` is 1 (bad address).
- R12: Priority is reset, then exception, then control transfer, then halt hold, then increment. An exception overrides any code, suppresses `flag_clr` and does not set the halted state. A transfer overrides the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl | input | 4 | Decoded control class code |
| exc_valid | input | 1 | Exception redirect request |
| exc_kind | input | 1 | Exception type: 0 empty stack, 1 bad address |
| int_idx | input | 2 | Software interrupt index |
| flags | input | 3 | Condition flags: bit 0 zero, bit 1 negative, bit 2 carry |
| jmp_target | input | 32 | Register jump or call target |
| pop_addr | input | 32 | Return address popped from the stack |
| vec_words | input | 160 | Instruction words 0 to 9, word k at bits [16k+15:16k] |
| pc | output | 32 | Current program counter |
| push_val | output | 32 | PC+1, value to push on call or interrupt |
| flag_clr | output | 3 | Clear request for the flag a taken conditional jump tested |

## Verification
`flag_clr` and `push_val` are combinational, so they are due in the same cycle as their stimulus. The PC is due one rising edge after its stimulus. The driver applies inputs on the falling edge and samples the combinational outputs 1 ns later. It then pushes the expected PC into a queue. A monitor pops that entry 2 ns after the following rising edge, so every PC comparison lands after the single register stage and before the next stimulus.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 0;
  localparam int FLAG_N_BIT = 1;
  localparam int FLAG_C = 2;

  typedef enum logic [3:0] {
    CT_SEQ  = 4'd0,
    CT_HALT = 4'd1,
    CT_JMP  = 4'd2,
    CT_JZ   = 4'd3,
    CT_JN   = 4'd4,
    CT_JC   = 4'd5,
    CT_CALL = 4'd6,
    CT_RET  = 4'd7,
    CT_INT  = 4'd8,
    CT_RTI  = 4'd9
  } ctl_e;
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval
  import pc_seq_pkg::*;
(
  input  logic [3:0]        ctl,
  input  logic [FLAG_N-1:0] flags,
  input  logic              allow,
  output logic              taken,
  output logic [FLAG_N-1:0] clr
);
  logic [FLAG_N-1:0] tested;

  always_comb begin
    tested = '0;
    case (ctl)
      CT_JZ:   tested[FLAG_Z]     = 1'b1;
      CT_JN:   tested[FLAG_N_BIT] = 1'b1;
      CT_JC:   tested[FLAG_C]     = 1'b1;
      default: tested = '0;
    endcase
  end

  assign taken = |(tested & flags);
  assign clr   = (allow && taken) ? tested : '0;
endmodule

// File: rtl/pc_vec_pick.sv
module pc_vec_pick #(
  parameter int IW    = 16,
  parameter int VEC_N = 10
) (
  input  logic [VEC_N*IW-1:0] vec_words,
  input  logic                exc_kind,
  input  logic [1:0]          int_idx,
  output logic [2*IW-1:0]     boot_addr,
  output logic [2*IW-1:0]     exc_addr,
  output logic [2*IW-1:0]     int_addr
);
  localparam int BOOT_BASE  = 0;
  localparam int STACK_BASE = 2;
  localparam int ADDR_BASE  = 4;
  localparam int INT_BASE   = 6;

  logic [IW-1:0] word [VEC_N];

  for (genvar k = 0; k < VEC_N; k++) begin : g_unpack
    assign word[k] = vec_words[k*IW +: IW];
  end

  function automatic logic [2*IW-1:0] join_pair(input logic [IW-1:0] hi,
                                                input logic [IW-1:0] lo);
    return {hi, lo};
  endfunction

  assign boot_addr = join_pair(word[BOOT_BASE], word[BOOT_BASE+1]);
  assign exc_addr  = exc_kind ? join_pair(word[ADDR_BASE],  word[ADDR_BASE+1])
                              : join_pair(word[STACK_BASE], word[STACK_BASE+1]);
  assign int_addr  = (int_idx == 2'd2) ? join_pair(word[INT_BASE+2], word[INT_BASE+3])
                                       : join_pair(word[INT_BASE],   word[INT_BASE+1]);
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_seq_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic           rst,
  input  logic [3:0]     ctl,
  input  logic           exc_valid,
  input  logic           cond_taken,
  input  logic           halted_q,
  input  logic [PCW-1:0] pc_q,
  input  logic [PCW-1:0] jmp_target,
  input  logic [PCW-1:0] pop_addr,
  input  logic [PCW-1:0] boot_addr,
  input  logic [PCW-1:0] exc_addr,
  input  logic [PCW-1:0] int_addr,
  output logic [PCW-1:0] pc_d,
  output logic           halted_d,
  output logic           take_exc,
  output logic           take_xfer,
  output logic           hold
);
  function automatic logic [PCW-1:0] pc_step(input logic [PCW-1:0] cur);
    return cur + PCW'(1);
  endfunction

  logic           xfer;
  logic [PCW-1:0] xfer_addr;

  always_comb begin
    xfer      = 1'b0;
    xfer_addr = jmp_target;
    case (ctl)
      CT_JMP, CT_CALL:     xfer = 1'b1;
      CT_JZ, CT_JN, CT_JC: xfer = cond_taken;
      CT_RET, CT_RTI: begin
        xfer      = 1'b1;
        xfer_addr = pop_addr;
      end
      CT_INT: begin
        xfer      = 1'b1;
        xfer_addr = int_addr;
      end
      default: xfer = 1'b0;
    endcase
  end

  assign take_exc  = !rst && exc_valid;
  assign take_xfer = !rst && !exc_valid && xfer;
  assign hold      = !rst && !exc_valid && !xfer && (halted_q || ctl == CT_HALT);

  always_comb begin
    if (rst)            pc_d = boot_addr;
    else if (take_exc)  pc_d = exc_addr;
    else if (take_xfer) pc_d = xfer_addr;
    else if (hold)      pc_d = pc_q;
    else                pc_d = pc_step(pc_q);
  end

  assign halted_d = rst ? 1'b0 : (halted_q || (!exc_valid && ctl == CT_HALT));
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pc_seq_pkg::*;
#(
  parameter int IW    = 16,
  parameter int VEC_N = 10,
  localparam int PCW  = 2 * IW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          ctl,
  input  logic                exc_valid,
  input  logic                exc_kind,
  input  logic [1:0]          int_idx,
  input  logic [FLAG_N-1:0]   flags,
  input  logic [PCW-1:0]      jmp_target,
  input  logic [PCW-1:0]      pop_addr,
  input  logic [VEC_N*IW-1:0] vec_words,
  output logic [PCW-1:0]      pc,
  output logic [PCW-1:0]      push_val,
  output logic [FLAG_N-1:0]   flag_clr
);
  function automatic logic [PCW-1:0] ret_of(input logic [PCW-1:0] cur);
    return cur + PCW'(1);
  endfunction

  logic [PCW-1:0] pc_q, pc_d;
  logic           halted_q, halted_d;
  logic           cond_taken, take_exc, take_xfer, hold;
  logic [PCW-1:0] boot_addr, exc_addr, int_addr;

  pc_cond_eval u_cond (
    .ctl   (ctl),
    .flags (flags),
    .allow (!rst && !exc_valid),
    .taken (cond_taken),
    .clr   (flag_clr)
  );

  pc_vec_pick #(.IW(IW), .VEC_N(VEC_N)) u_vec (
    .vec_words (vec_words),
    .exc_kind  (exc_kind),
    .int_idx   (int_idx),
    .boot_addr (boot_addr),
    .exc_addr  (exc_addr),
    .int_addr  (int_addr)
  );

  pc_next_sel #(.PCW(PCW)) u_sel (
    .rst        (rst),
    .ctl        (ctl),
    .exc_valid  (exc_valid),
    .cond_taken (cond_taken),
    .halted_q   (halted_q),
    .pc_q       (pc_q),
    .jmp_target (jmp_target),
    .pop_addr   (pop_addr),
    .boot_addr  (boot_addr),
    .exc_addr   (exc_addr),
    .int_addr   (int_addr),
    .pc_d       (pc_d),
    .halted_d   (halted_d),
    .take_exc   (take_exc),
    .take_xfer  (take_xfer),
    .hold       (hold)
  );

  always_ff @(posedge clk) begin
    pc_q     <= pc_d;
    halted_q <= halted_d;
  end

  assign pc       = pc_q;
  assign push_val = ret_of(pc_q);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!exc_valid && !halted_q && ctl == CT_SEQ) |=> pc == $past(pc) + PCW'(1));

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(pc));

  assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q);

  assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr));

  assert_ret_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (!exc_valid && (ctl == CT_RET || ctl == CT_RTI)) |=> pc == $past(pop_addr));

  assert_exc_vec_R11: assert property (@(posedge clk) disable iff (rst)
    take_exc |=> pc == $past(exc_addr));

  assert_exc_no_clr_R12: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> flag_clr == '0);
endmodule

// File: tb/test_pc_seq_unit.sv
`timescale 1ns/1ps
module test_pc_seq_unit;
  import pc_seq_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   ctl = 4'd0;
  logic         exc_valid = 1'b0;
  logic         exc_kind = 1'b0;
  logic [1:0]   int_idx = 2'd0;
  logic [2:0]   flags = 3'd0;
  logic [31:0]  jmp_target = '0;
  logic [31:0]  pop_addr = '0;
  logic [159:0] vec_words;
  logic [31:0]  pc, push_val;
  logic [2:0]   flag_clr;

  logic [15:0] w [10];
  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc;
  bit          m_halt;
  logic [31:0] expq [$];
  string       tagq [$];

  always #2.5 clk = ~clk;

  initial begin
    w[0] = 16'h0000; w[1] = 16'h0100;
    w[2] = 16'h0001; w[3] = 16'h2000;
    w[4] = 16'h0002; w[5] = 16'h3000;
    w[6] = 16'h0003; w[7] = 16'h4000;
    w[8] = 16'h0004; w[9] = 16'h5000;
  end
  always_comb for (int k = 0; k < 10; k++) vec_words[k*16 +: 16] = w[k];

  pc_seq_unit i_pc_seq_unit (
    .clk(clk), .rst(rst), .ctl(ctl), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .int_idx(int_idx), .flags(flags), .jmp_target(jmp_target), .pop_addr(pop_addr),
    .vec_words(vec_words), .pc(pc), .push_val(push_val), .flag_clr(flag_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(pc === e, t, pc, e);
    end
  end

  task automatic step(input bit r, input logic [3:0] c, input bit ev, input bit ek,
                      input logic [1:0] ix, input logic [2:0] f,
                      input logic [31:0] tgt, input logic [31:0] pop, input string tag);
    logic [2:0]  tested;
    logic [2:0]  exp_clr;
    bit          jump;
    logic [31:0] nxt;
    @(negedge clk);
    rst = r; ctl = c; exc_valid = ev; exc_kind = ek; int_idx = ix;
    flags = f; jmp_target = tgt; pop_addr = pop;
    #1;
    tested = (c == 4'd3) ? 3'b001 : (c == 4'd4) ? 3'b010 : (c == 4'd5) ? 3'b100 : 3'b000;
    exp_clr = (!r && !ev && (tested & f) != 0) ? tested : 3'b000;
    chk(flag_clr === exp_clr, {tag, " flag_clr R6"}, {29'd0, flag_clr}, {29'd0, exp_clr});
    if (!r && (c == 4'd6 || c == 4'd8))
      chk(push_val === m_pc + 32'd1, "R7 push_val", push_val, m_pc + 32'd1);
    jump = 1'b0;
    nxt  = tgt;
    case (c)
      4'd2, 4'd6: jump = 1'b1;
      4'd3, 4'd4, 4'd5: jump = (tested & f) != 0;
      4'd7, 4'd9: begin jump = 1'b1; nxt = pop; end
      4'd8: begin jump = 1'b1; nxt = (ix == 2'd2) ? {w[8], w[9]} : {w[6], w[7]}; end
      default: jump = 1'b0;
    endcase
    if (r) begin
      m_pc = {w[0], w[1]}; m_halt = 1'b0;
    end else if (ev) begin
      m_pc = ek ? {w[4], w[5]} : {w[2], w[3]};
    end else if (jump) begin
      m_pc = nxt;
    end else if (m_halt || c == 4'd1) begin
      m_halt = 1'b1;
    end else begin
      m_pc = m_pc + 32'd1;
    end
    expq.push_back(m_pc);
    tagq.push_back(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_pc = '0; m_halt = 1'b0;
    step(1, CT_SEQ, 0, 0, 0, 0, 0, 0, "R1 reset vector");
    step(1, CT_SEQ, 0, 0, 0, 0, 0, 0, "R1 reset vector held");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R2 increment");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R2 increment again");
    step(0, CT_JMP, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, "R4 jump");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R2 wrap to zero");
    step(0, 4'd12, 0, 0, 0, 0, 32'h77, 0, "R2 unused code increments");
    step(0, CT_JZ, 0, 0, 0, 3'b001, 32'h500, 0, "R5 JZ taken");
    step(0, CT_JZ, 0, 0, 0, 3'b110, 32'h900, 0, "R5 JZ not taken");
    step(0, CT_JN, 0, 0, 0, 3'b010, 32'h600, 0, "R5 JN taken");
    step(0, CT_JC, 0, 0, 0, 3'b100, 32'h700, 0, "R5 JC taken");
    step(0, CT_JN, 0, 0, 0, 3'b101, 32'h800, 0, "R5 JN not taken");
    step(0, CT_CALL, 0, 0, 0, 0, 32'h1234, 0, "R8 call target");
    step(0, CT_RET, 0, 0, 0, 0, 0, 32'h702, "R10 return pop");
    step(0, CT_INT, 0, 0, 2'd0, 0, 0, 0, "R9 interrupt index 0");
    step(0, CT_INT, 0, 0, 2'd2, 0, 0, 0, "R9 interrupt index 2");
    step(0, CT_INT, 0, 0, 2'd1, 0, 0, 0, "R9 interrupt index 1 as 0");
    step(0, CT_INT, 0, 0, 2'd3, 0, 0, 0, "R9 interrupt index 3 as 0");
    step(0, CT_RTI, 0, 0, 0, 0, 0, 32'h0000_ABCD, "R10 return from interrupt");
    step(0, CT_JZ, 1, 0, 0, 3'b001, 32'h999, 0, "R11 R12 empty stack over JZ");
    step(0, CT_JMP, 1, 1, 0, 0, 32'h999, 0, "R11 R12 bad address over jump");
    step(0, CT_HALT, 0, 0, 0, 0, 0, 0, "R3 halt holds");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R3 halted stays");
    step(0, 4'd13, 0, 0, 0, 0, 0, 0, "R3 halted ignores unused code");
    step(0, CT_SEQ, 1, 0, 0, 0, 0, 0, "R12 exception while halted");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R3 still halted after exception");
    step(0, CT_JMP, 0, 0, 0, 0, 32'h40, 0, "R12 transfer overrides halt");
    step(0, CT_JZ, 0, 0, 0, 3'b000, 32'h80, 0, "R3 halted JZ not taken");
    step(1, CT_SEQ, 0, 0, 0, 0, 0, 0, "R1 reset clears halt");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R1 R2 increments after reset");
    step(0, CT_HALT, 1, 1, 0, 0, 0, 0, "R12 exception beats halt");
    step(0, CT_SEQ, 0, 0, 0, 0, 0, 0, "R12 halt not set under exception");
    @(negedge clk);
    ctl = CT_SEQ;
    repeat (2) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule